// File: doc/BRIEF.md
# Performance State Transition Sequencer

This block moves a core between voltage/frequency operating points after software writes a new target. A single-cycle write carries a requested core-to-bus clock ratio and a requested voltage code. The block then drives the voltage code to the regulator and the core ratio to the clock multiplier in a safe order. When the ratio goes up, the voltage is raised first and the ratio follows. When the ratio goes down, the ratio drops first and the voltage follows. The bus clock is never touched. Only the core ratio output changes.

The voltage code moves one code at a time, and each code is 12.5 mV. A higher code means a higher voltage. Between two steps, and after the last step, the block waits a programmable dwell so the regulator can settle. A requested ratio above the configured maximum is clamped to that maximum. A busy flag covers the whole transition, and writes that arrive while it is set are dropped.

Top module: `pstate_seq`

## Requirements
- R1: After reset, coreRatio equals DEF_RATIO (10), vidOut equals DEF_VID (48) and busy is low.
- R2: A write with wrEn high while busy is low is accepted at that clock edge, and busy is high from the following cycle. With N = |target VID − current VID| and D = dwellCycles, busy stays high for exactly 1 + N·(D+1) cycles.
- R3: Each change of vidOut is exactly one code, +1 or −1. Successive changes are D+1 cycles apart, and the first change comes one cycle after acceptance.
- R4: If the clamped target ratio is above the current ratio, coreRatio keeps its old value while busy is high. It takes the new value on the same edge where busy falls, which is after vidOut has reached its target.
- R5: If the clamped target ratio is below the current ratio, coreRatio takes the new value at the acceptance edge, before any VID step.
- R6: If the clamped target ratio equals the current ratio, only vidOut moves and coreRatio stays constant.
- R7: A requested ratio above MAX_RATIO (20) is replaced by MAX_RATIO, and coreRatio never exceeds MAX_RATIO.
- R8: A write that arrives while busy is high changes neither the target nor the timing of the transition in progress.
- R9: When busy falls, vidOut equals the VID code that was written, stepping either up (higher voltage) or down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Target write strobe |
| wrRatio | input | RATIO_W | Requested core-to-bus ratio |
| wrVid | input | VID_W | Requested VID code (higher = higher voltage) |
| dwellCycles | input | DWELL_W | Settling wait between VID steps |
| vidOut | output | VID_W | VID code to the regulator |
| coreRatio | output | RATIO_W | Core ratio to the clock multiplier |
| busy | output | 1 | Transition in progress |

## Verification
A fault in the dwell counter shows up at the ports as a VID step that comes early or late, and as a busy length that differs from 1 + N·(D+1) as soon as the first transition ends. A wrong order decision shows up right away: the ratio changes at the acceptance edge on an upward move, or holds on a downward one. A write that wrongly reloads the target changes the final vidOut or coreRatio of that transition.

// File: rtl/pstate_seq_pkg.sv
package pstate_seq_pkg;
  typedef struct packed {
    logic load;      // latch clamped target ratio and target vid
    logic applyWr;   // apply written ratio immediately (downward move)
    logic applyTgt;  // apply latched target ratio at the end
    logic step;      // move vid one code toward target
  } seqStrb_t;
endpackage

// File: rtl/pstate_seq_dp.sv
module pstate_seq_dp
  import pstate_seq_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int VID_W     = 7,
  parameter int MAX_RATIO = 20,
  parameter int DEF_RATIO = 10,
  parameter int DEF_VID   = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrb_t           strb,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [VID_W-1:0]   wrVid,
  output logic               ratioDown,
  output logic               vidAtTgt,
  output logic [VID_W-1:0]   vidOut,
  output logic [RATIO_W-1:0] coreRatio
);
  localparam logic [RATIO_W-1:0] MaxR = RATIO_W'(MAX_RATIO);
  localparam logic [RATIO_W-1:0] DefR = RATIO_W'(DEF_RATIO);
  localparam logic [VID_W-1:0]   DefV = VID_W'(DEF_VID);

  logic [RATIO_W-1:0] clampRatio, tgtRatio, curRatio;
  logic [VID_W-1:0]   tgtVid, curVid;
  logic               vidUp;

  assign clampRatio = (wrRatio > MaxR) ? MaxR : wrRatio;
  assign ratioDown  = clampRatio < curRatio;
  assign vidAtTgt   = curVid == tgtVid;
  assign vidUp      = tgtVid > curVid;
  assign vidOut     = curVid;
  assign coreRatio  = curRatio;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtRatio <= DefR;
      tgtVid   <= DefV;
      curRatio <= DefR;
      curVid   <= DefV;
    end else begin
      if (strb.load) begin
        tgtRatio <= clampRatio;
        tgtVid   <= wrVid;
      end
      if (strb.applyWr)  curRatio <= clampRatio;
      if (strb.applyTgt) curRatio <= tgtRatio;
      if (strb.step)     curVid   <= vidUp ? curVid + 1'b1 : curVid - 1'b1;
    end
  end

  // R7
  ratio_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    curRatio <= MaxR);
  // R3
  vid_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curVid) |-> (curVid == $past(curVid) + 1'b1 || curVid == $past(curVid) - 1'b1));
  // R4
  ratio_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curRatio > $past(curRatio)) |-> (curVid == tgtVid));
endmodule

// File: rtl/pstate_seq_ctrl.sv
module pstate_seq_ctrl
  import pstate_seq_pkg::*;
#(
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DWELL_W-1:0] dwellCycles,
  input  logic               ratioDown,
  input  logic               vidAtTgt,
  output seqStrb_t           strb,
  output logic               busy
);
  typedef enum logic {S_IDLE, S_STEP} seqState_t;
  seqState_t state;
  logic [DWELL_W-1:0] dwellCnt;

  assign busy = (state == S_STEP);

  always_comb begin
    strb = '0;
    if (state == S_IDLE) begin
      if (wrEn) begin
        strb.load    = 1'b1;
        strb.applyWr = ratioDown;
      end
    end else if (dwellCnt == '0) begin
      if (vidAtTgt) strb.applyTgt = 1'b1;
      else          strb.step     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      dwellCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (wrEn) begin
          state    <= S_STEP;
          dwellCnt <= '0;
        end
        S_STEP: begin
          if (dwellCnt != '0)  dwellCnt <= dwellCnt - 1'b1;
          else if (vidAtTgt)   state    <= S_IDLE;
          else                 dwellCnt <= dwellCycles;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !vidAtTgt) |=> busy);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> vidAtTgt);
endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
  import pstate_seq_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int VID_W     = 7,
  parameter int DWELL_W   = 4,
  parameter int MAX_RATIO = 20,
  parameter int DEF_RATIO = 10,
  parameter int DEF_VID   = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [VID_W-1:0]   wrVid,
  input  logic [DWELL_W-1:0] dwellCycles,
  output logic [VID_W-1:0]   vidOut,
  output logic [RATIO_W-1:0] coreRatio,
  output logic               busy
);
  seqStrb_t strb;
  logic ratioDown, vidAtTgt;

  pstate_seq_ctrl #(.DWELL_W(DWELL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .dwellCycles(dwellCycles),
    .ratioDown(ratioDown), .vidAtTgt(vidAtTgt), .strb(strb), .busy(busy)
  );

  pstate_seq_dp #(
    .RATIO_W(RATIO_W), .VID_W(VID_W), .MAX_RATIO(MAX_RATIO),
    .DEF_RATIO(DEF_RATIO), .DEF_VID(DEF_VID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrRatio(wrRatio), .wrVid(wrVid),
    .ratioDown(ratioDown), .vidAtTgt(vidAtTgt), .vidOut(vidOut), .coreRatio(coreRatio)
  );
endmodule

// File: tb/pstate_seq_bench.sv
module pstate_seq_bench;
  localparam int MAXR = 20;
  logic clk = 0, rstN = 0, wrEn = 0;
  logic [4:0] wrRatio = '0;
  logic [6:0] wrVid = '0;
  logic [3:0] dwellCycles = '0;
  logic [6:0] vidOut;
  logic [4:0] coreRatio;
  logic busy;
  int checks = 0, errors = 0;
  int curR = 10, curV = 48;

  always #10 clk = ~clk;

  pstate_seq u_pstate_seq (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRatio(wrRatio),
    .wrVid(wrVid), .dwellCycles(dwellCycles), .vidOut(vidOut),
    .coreRatio(coreRatio), .busy(busy));

  function automatic int clampR(int r); return (r > MAXR) ? MAXR : r; endfunction
  function automatic int absDiff(int a, int b); return (a > b) ? a - b : b - a; endfunction
  function automatic int expBusy(int n, int d); return 1 + n * (d + 1); endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic txn(int r, int v, int d, bit junk);
    int tr, n, bc, lastV, gap, stepGapBad, stepSizeBad, ratioBad, firstStep;
    tr = clampR(r);
    n = absDiff(v, curV);
    @(negedge clk);
    wrRatio = 5'(r); wrVid = 7'(v); dwellCycles = 4'(d); wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    check("R2 busy after accept", int'(busy), 1);
    if (tr < curR) check("R5 ratio applied first", int'(coreRatio), tr);
    else check("R4/R6 ratio held at accept", int'(coreRatio), curR);
    bc = 0; lastV = curV; gap = 0; stepGapBad = 0; stepSizeBad = 0; ratioBad = 0; firstStep = 1;
    while (busy && bc < 2000) begin
      bc++; gap++;
      if (int'(vidOut) != lastV) begin
        if (absDiff(int'(vidOut), lastV) != 1) stepSizeBad++;
        if (firstStep ? (gap != 2) : (gap != d + 1)) stepGapBad++;
        firstStep = 0; gap = 0; lastV = int'(vidOut);
      end
      if (tr >= curR && int'(coreRatio) != curR) ratioBad++;
      if (tr < curR && int'(coreRatio) != tr) ratioBad++;
      if (junk && bc == 2) begin
        wrEn = 1; wrRatio = 5'(31 - r); wrVid = 7'(127 - v);
      end else wrEn = 0;
      @(negedge clk);
    end
    wrEn = 0;
    check("R3 step size", stepSizeBad, 0);
    check("R3 dwell spacing", stepGapBad, 0);
    check("R4/R6 ratio while busy", ratioBad, 0);
    check("R2 busy length", bc, expBusy(n, d));
    check("R9 final vid", int'(vidOut), v);
    check("R7 final ratio clamped", int'(coreRatio), tr);
    if (junk) check("R8 junk write ignored busy", int'(busy), 0);
    curR = tr; curV = v;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset ratio", int'(coreRatio), 10);
    check("R1 reset vid", int'(vidOut), 48);
    check("R1 reset busy", int'(busy), 0);
    txn(31, 52, 2, 0);   // R7 clamp, R4 upward
    txn(20, 52, 1, 0);   // R6 equal ratio, no vid move
    txn(20, 49, 0, 1);   // R6 vid only, R8 junk write
    txn(6, 44, 3, 1);    // R5 downward
    txn(15, 50, 0, 0);   // R4 upward zero dwell
    for (int i = 0; i < 60; i++) begin
      int r, v, d;
      r = int'($urandom_range(31, 1));
      v = curV + int'($urandom_range(12, 0)) - 6;
      if (v < 0) v = 0;
      if (v > 127) v = 127;
      d = int'($urandom_range(4, 0));
      txn(r, v, d, 1'($urandom_range(1, 0)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule